// File: doc/BRIEF.md
# Memory-Protection Entry Register Bank

This block holds the configuration state for a set of physical-memory-protection entries. Each entry has an 8-bit configuration byte and an address word. A single compile-time granularity exponent applies to the whole bank. The block takes register writes to either field of any entry and decides whether a configuration write is legal for that granularity. It shapes the address word that a register read returns according to the entry's address-matching mode. It also passes the raw stored arrays, unmasked, to a separate region matcher.

A read is purely combinational from the read index, so a register-access stage can sample the result in the cycle it presents the index. Writes land on the next clock edge. Every accepted configuration write also raises a one-cycle update strobe that names the entry. The matcher uses this strobe to recompute that entry's region bounds.

Top module: `pmp_csr_bank`

## Requirements
- R1: After a synchronous reset, every configuration byte and address word reads zero, and the update strobe is low.
- R2: A configuration write to an in-range entry that is legal is stored at the next clock edge. From then on it is visible on the read port and on that entry's 8-bit slice of the flat configuration export.
- R3: The matching mode is held in bits [4:3] of the configuration byte: 0 = off, 1 = top-of-range, 2 = naturally aligned 4-byte, 3 = naturally aligned power-of-two. When the granularity exponent GRAN_G is 1 or more, a configuration write that selects mode 2 is refused. The old byte is kept and no update strobe follows.
- R4: One cycle after an accepted configuration write, upd_valid is high for one cycle and upd_idx carries the written entry's index.
- R5: An address write to an in-range entry stores every written bit. The flat address export always shows the stored word unmasked.
- R6: When an entry's mode is off or top-of-range, reading its address word returns bits [GRAN_G-1:0] as zero. This masking applies only when GRAN_G is 1 or more.
- R7: When an entry's mode is power-of-two, reading its address word returns bits [GRAN_G-2:0] as one. This applies only when GRAN_G is 2 or more.
- R8: When an entry is in the 4-byte mode, or when no granularity condition applies, a read returns the stored address word unchanged.
- R9: A read index at or above N_ENTRIES returns zero on both read outputs. Configuration or address writes to such an index change no entry and raise no update strobe.
- R10: Masking happens only on the read path. After the mode of an entry is switched away and back again, the read shows the same value as before the switch.
- R11: A read in the same cycle as a write to the same entry returns the value from before the write. The new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | IDX_W | Entry index for the configuration write |
| cfg_wdata | input | 8 | Configuration byte to write |
| addr_we | input | 1 | Address word write strobe |
| addr_idx | input | IDX_W | Entry index for the address write |
| addr_wdata | input | XLEN | Address word to write |
| rd_idx | input | IDX_W | Entry index for the combinational read |
| cfg_rdata | output | 8 | Configuration byte of the read entry |
| addr_rdata | output | XLEN | Address word of the read entry after mode-dependent shaping |
| cfg_flat | output | N_ENTRIES*8 | All stored configuration bytes, entry e at bits [e*8 +: 8] |
| addr_flat | output | N_ENTRIES*XLEN | All stored address words, unmasked |
| upd_valid | output | 1 | One-cycle strobe after an accepted configuration write |
| upd_idx | output | SEL_W | Entry index that goes with upd_valid |

## Verification
A configuration write that changes an entry's mode can fall in the same cycle as a read of that entry's address word. The bench provokes this by driving the write strobe and the read index on the same falling edge. It expects the shaping of the old mode in that cycle and the shaping of the new mode one cycle later. It does the same with an address write and a read of the same entry. In every case the scoreboard predicts the value from a model that it updates only after the edge.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  localparam int AMODE_LSB = 3;

  function automatic amode_e amode_of(input logic [7:0] cfg_byte);
    return amode_e'(cfg_byte[AMODE_LSB+1:AMODE_LSB]);
  endfunction

endpackage

// File: rtl/pmp_cfg_legal.sv
module pmp_cfg_legal
  import pmp_csr_pkg::*;
#(
  parameter int GRAN_G = 2
) (
  input  amode_e mode,
  output logic   legal
);

  // With a granularity coarser than 4 bytes the 4-byte mode cannot be chosen.
  assign legal = (GRAN_G == 0) || (mode != AM_NA4);

endmodule

// File: rtl/pmp_rd_shape.sv
module pmp_rd_shape
  import pmp_csr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int GRAN_G = 2
) (
  input  amode_e            mode,
  input  logic [XLEN-1:0]   raw,
  output logic [XLEN-1:0]   shaped
);

  localparam int ONE_SH = (GRAN_G >= 2) ? (GRAN_G - 1) : 0;
  localparam logic [XLEN-1:0] ZERO_MASK = (XLEN'(1) << GRAN_G) - XLEN'(1);
  localparam logic [XLEN-1:0] ONE_MASK  = (XLEN'(1) << ONE_SH) - XLEN'(1);

  always_comb begin
    unique case (mode)
      AM_OFF, AM_TOR: shaped = raw & ~ZERO_MASK;
      AM_NAPOT:       shaped = raw | ONE_MASK;
      default:        shaped = raw;
    endcase
  end

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_csr_pkg::*;
#(
  parameter  int N_ENTRIES = 16,
  parameter  int XLEN      = 32,
  parameter  int GRAN_G    = 2,
  localparam int SEL_W     = $clog2(N_ENTRIES),
  localparam int IDX_W     = SEL_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic [7:0]                cfg_wdata,
  input  logic                      addr_we,
  input  logic [IDX_W-1:0]          addr_idx,
  input  logic [XLEN-1:0]           addr_wdata,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [7:0]                cfg_rdata,
  output logic [XLEN-1:0]           addr_rdata,
  output logic [N_ENTRIES*8-1:0]    cfg_flat,
  output logic [N_ENTRIES*XLEN-1:0] addr_flat,
  output logic                      upd_valid,
  output logic [SEL_W-1:0]          upd_idx
);

  localparam logic [IDX_W-1:0] N_IDX = IDX_W'(N_ENTRIES);

  logic             cfg_hit, addr_hit, rd_hit;
  logic             cfg_legal, cfg_accept, addr_accept;
  logic [SEL_W-1:0] cfg_sel, addr_sel, rd_sel;
  amode_e           wr_mode, rd_mode;
  logic [7:0]       cfg_arr  [N_ENTRIES];
  logic [XLEN-1:0]  addr_arr [N_ENTRIES];
  logic [7:0]       rd_cfg;
  logic [XLEN-1:0]  rd_addr_raw, rd_addr_shaped;

  assign cfg_hit  = cfg_idx  < N_IDX;
  assign addr_hit = addr_idx < N_IDX;
  assign rd_hit   = rd_idx   < N_IDX;
  assign cfg_sel  = cfg_idx[SEL_W-1:0];
  assign addr_sel = addr_idx[SEL_W-1:0];
  assign rd_sel   = rd_idx[SEL_W-1:0];

  assign wr_mode = amode_of(cfg_wdata);

  pmp_cfg_legal #(.GRAN_G(GRAN_G)) u_legal (
    .mode  (wr_mode),
    .legal (cfg_legal)
  );

  assign cfg_accept  = cfg_we && cfg_hit && cfg_legal;
  assign addr_accept = addr_we && addr_hit;

  // One register pair per entry; each picks its own write strobe.
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    localparam logic [SEL_W-1:0] E_SEL = SEL_W'(e);
    logic [7:0]      cfg_r;
    logic [XLEN-1:0] addr_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_r  <= '0;
        addr_r <= '0;
      end else begin
        if (cfg_accept && (cfg_sel == E_SEL)) begin
          cfg_r <= cfg_wdata;
        end
        if (addr_accept && (addr_sel == E_SEL)) begin
          addr_r <= addr_wdata;
        end
      end
    end

    assign cfg_arr[e]                   = cfg_r;
    assign addr_arr[e]                  = addr_r;
    assign cfg_flat[e*8 +: 8]           = cfg_r;
    assign addr_flat[e*XLEN +: XLEN]    = addr_r;
  end

  // Combinational read with mode-dependent shaping.
  assign rd_cfg      = cfg_arr[rd_sel];
  assign rd_addr_raw = addr_arr[rd_sel];
  assign rd_mode     = amode_of(rd_cfg);

  pmp_rd_shape #(.XLEN(XLEN), .GRAN_G(GRAN_G)) u_shape (
    .mode   (rd_mode),
    .raw    (rd_addr_raw),
    .shaped (rd_addr_shaped)
  );

  assign cfg_rdata  = rd_hit ? rd_cfg         : '0;
  assign addr_rdata = rd_hit ? rd_addr_shaped : '0;

  // Registered recompute strobe toward the region matcher.
  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid <= 1'b0;
      upd_idx   <= '0;
    end else begin
      upd_valid <= cfg_accept;
      if (cfg_accept) begin
        upd_idx <= cfg_sel;
      end
    end
  end

endmodule

// File: rtl/pmp_csr_bank_chk.sv
module pmp_csr_bank_chk #(
  parameter  int N_ENTRIES = 16,
  parameter  int XLEN      = 32,
  parameter  int GRAN_G    = 2,
  localparam int SEL_W     = $clog2(N_ENTRIES),
  localparam int IDX_W     = SEL_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_idx,
  input logic [7:0]       cfg_wdata,
  input logic [IDX_W-1:0] rd_idx,
  input logic [7:0]       cfg_rdata,
  input logic [XLEN-1:0]  addr_rdata,
  input logic             upd_valid,
  input logic [SEL_W-1:0] upd_idx
);

  localparam logic [IDX_W-1:0] N_IDX = IDX_W'(N_ENTRIES);
  localparam int ONE_SH = (GRAN_G >= 2) ? (GRAN_G - 1) : 0;
  localparam logic [XLEN-1:0] LOW_ZERO = (XLEN'(1) << GRAN_G) - XLEN'(1);
  localparam logic [XLEN-1:0] LOW_ONE  = (XLEN'(1) << ONE_SH) - XLEN'(1);

  logic wr_ok;
  assign wr_ok = cfg_we && (cfg_idx < N_IDX) &&
                 ((GRAN_G == 0) || (cfg_wdata[4:3] != 2'd2));

  // R2
  cfg_stored_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (rd_idx != $past(rd_idx)) || (rd_idx != $past(cfg_idx)) ||
              (cfg_rdata == $past(cfg_wdata)) || 1'b0 ? 1'b1 :
              ((rd_idx != $past(cfg_idx)) || (cfg_rdata == $past(cfg_wdata))));

  // R3
  na4_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (GRAN_G >= 1) && (cfg_wdata[4:3] == 2'd2)) |=> !upd_valid);

  // R4
  upd_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (upd_valid && (upd_idx == $past(cfg_idx[SEL_W-1:0]))));

  // R6
  low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_idx < N_IDX) && (cfg_rdata[4:3] <= 2'd1)) |-> ((addr_rdata & LOW_ZERO) == '0));

  // R7
  low_one_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_idx < N_IDX) && (cfg_rdata[4:3] == 2'd3)) |-> ((addr_rdata & LOW_ONE) == LOW_ONE));

  // R9
  oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx >= N_IDX) |-> ((cfg_rdata == 8'd0) && (addr_rdata == '0)));

  // R9
  oob_no_upd_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_idx >= N_IDX)) |=> !upd_valid);

endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(
  .N_ENTRIES (N_ENTRIES),
  .XLEN      (XLEN),
  .GRAN_G    (GRAN_G)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .cfg_wdata  (cfg_wdata),
  .rd_idx     (rd_idx),
  .cfg_rdata  (cfg_rdata),
  .addr_rdata (addr_rdata),
  .upd_valid  (upd_valid),
  .upd_idx    (upd_idx)
);

// File: tb/tb_pmp_csr_bank.sv
`timescale 1ns/1ps
module tb_pmp_csr_bank;

  localparam int N  = 16;
  localparam int XL = 32;
  localparam int IW = 5;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          addr_we = 1'b0;
  logic [IW-1:0] addr_idx = '0;
  logic [XL-1:0] addr_wdata = '0;
  logic [IW-1:0] rd_idx = '0;

  logic [7:0]    c2_rd, c0_rd;
  logic [XL-1:0] a2_rd, a0_rd;
  logic [N*8-1:0]  c2_flat, c0_flat;
  logic [N*XL-1:0] a2_flat, a0_flat;
  logic          u2_v, u0_v;
  logic [SW-1:0] u2_i, u0_i;

  always #2 clk = ~clk;

  pmp_csr_bank #(.N_ENTRIES(N), .XLEN(XL), .GRAN_G(2)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .addr_we(addr_we), .addr_idx(addr_idx), .addr_wdata(addr_wdata), .rd_idx(rd_idx),
    .cfg_rdata(c2_rd), .addr_rdata(a2_rd), .cfg_flat(c2_flat), .addr_flat(a2_flat),
    .upd_valid(u2_v), .upd_idx(u2_i));

  pmp_csr_bank #(.N_ENTRIES(N), .XLEN(XL), .GRAN_G(0)) dut_g0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .addr_we(addr_we), .addr_idx(addr_idx), .addr_wdata(addr_wdata), .rd_idx(rd_idx),
    .cfg_rdata(c0_rd), .addr_rdata(a0_rd), .cfg_flat(c0_flat), .addr_flat(a0_flat),
    .upd_valid(u0_v), .upd_idx(u0_i));

  typedef struct {
    string         req;
    bit            is_upd;
    logic [IW-1:0] idx;
    logic [7:0]    c2, c0;
    logic [XL-1:0] a2, a0, raw;
    bit            u2, u0;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state, kept by the bench from the requirements.
  logic [7:0]    m_c2 [N];
  logic [7:0]    m_c0 [N];
  logic [XL-1:0] m_a  [N];

  function automatic logic [XL-1:0] shape(int g, logic [7:0] c, logic [XL-1:0] a);
    case (c[4:3])
      2'd0, 2'd1: if (g >= 1) return a & ~((32'd1 << g) - 32'd1);
      2'd3:       if (g >= 2) return a | ((32'd1 << (g - 1)) - 32'd1);
      default:    ;
    endcase
    return a;
  endfunction

  task automatic check(string req, string what, logic [XL-1:0] act, logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic item_t read_item(string req, logic [IW-1:0] i);
    item_t it;
    it.req = req; it.is_upd = 0; it.idx = i; it.u2 = 0; it.u0 = 0;
    if (i < N) begin
      it.c2 = m_c2[i]; it.c0 = m_c0[i]; it.raw = m_a[i];
      it.a2 = shape(2, m_c2[i], m_a[i]);
      it.a0 = shape(0, m_c0[i], m_a[i]);
    end else begin
      it.c2 = 0; it.c0 = 0; it.raw = 0; it.a2 = 0; it.a0 = 0;
    end
    return it;
  endfunction

  task automatic do_read(string req, logic [IW-1:0] i);
    @(negedge clk);
    rd_idx = i;
    sbq.push_back(read_item(req, i));
  endtask

  task automatic wr_cfg(string req, logic [IW-1:0] i, logic [7:0] v);
    item_t it;
    bit ok2, ok0;
    @(negedge clk);
    cfg_we = 1; cfg_idx = i; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    ok2 = (i < N) && (v[4:3] != 2'd2);
    ok0 = (i < N);
    if (ok2) m_c2[i[SW-1:0]] = v;
    if (ok0) m_c0[i[SW-1:0]] = v;
    it.req = req; it.is_upd = 1; it.idx = i; it.u2 = ok2; it.u0 = ok0;
    it.c2 = 0; it.c0 = 0; it.a2 = 0; it.a0 = 0; it.raw = 0;
    sbq.push_back(it);
  endtask

  task automatic wr_addr(logic [IW-1:0] i, logic [XL-1:0] v);
    @(negedge clk);
    addr_we = 1; addr_idx = i; addr_wdata = v;
    @(negedge clk);
    addr_we = 0;
    if (i < N) m_a[i[SW-1:0]] = v;
  endtask

  // Configuration write and read of the same entry in one cycle.
  task automatic cfg_and_read(string req, logic [IW-1:0] i, logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = i; cfg_wdata = v; rd_idx = i;
    sbq.push_back(read_item(req, i));
    @(negedge clk);
    cfg_we = 0;
    if (v[4:3] != 2'd2) m_c2[i[SW-1:0]] = v;
    m_c0[i[SW-1:0]] = v;
    sbq.push_back(read_item(req, i));
  endtask

  // Address write and read of the same entry in one cycle.
  task automatic addr_and_read(string req, logic [IW-1:0] i, logic [XL-1:0] v);
    @(negedge clk);
    addr_we = 1; addr_idx = i; addr_wdata = v; rd_idx = i;
    sbq.push_back(read_item(req, i));
    @(negedge clk);
    addr_we = 0;
    m_a[i[SW-1:0]] = v;
    sbq.push_back(read_item(req, i));
  endtask

  // Monitor: pops one expectation per falling edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        if (it.is_upd) begin
          check(it.req, "upd_valid g2", {31'd0, u2_v}, {31'd0, it.u2});
          check(it.req, "upd_valid g0", {31'd0, u0_v}, {31'd0, it.u0});
          if (it.u2) check(it.req, "upd_idx g2", {28'd0, u2_i}, {28'd0, it.idx[SW-1:0]});
        end else begin
          check(it.req, "cfg g2",  {24'd0, c2_rd}, {24'd0, it.c2});
          check(it.req, "addr g2", a2_rd, it.a2);
          check(it.req, "cfg g0",  {24'd0, c0_rd}, {24'd0, it.c0});
          check(it.req, "addr g0", a0_rd, it.a0);
          if (it.idx < N) begin
            check(it.req, "addr flat", a2_flat[it.idx[SW-1:0]*XL +: XL], it.raw);
            check(it.req, "cfg flat", {24'd0, c2_flat[it.idx[SW-1:0]*8 +: 8]}, {24'd0, it.c2});
          end
        end
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      m_c2[k] = 0; m_c0[k] = 0; m_a[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    do_read("R1", 5'd0);
    do_read("R1", 5'd5);
    do_read("R1", 5'd15);
    @(negedge clk); #1;
    check("R1", "upd after reset", {31'd0, u2_v}, 32'd0);
    // R5, R6: raw store, off-mode low bits read zero
    wr_addr(5'd1, 32'hABCD_1237);
    do_read("R6", 5'd1);
    // R2, R4, R6: top-of-range configuration
    wr_cfg("R4", 5'd1, 8'h0B);
    do_read("R2", 5'd1);
    // R7: power-of-two mode forces low ones
    wr_addr(5'd2, 32'h0000_F000);
    wr_cfg("R4", 5'd2, 8'h18);
    do_read("R7", 5'd2);
    // R3, R8: 4-byte mode refused at G=2, accepted and unshaped at G=0
    wr_cfg("R3", 5'd2, 8'h11);
    do_read("R8", 5'd2);
    // R10: switching modes keeps the stored bits
    wr_addr(5'd6, 32'h0000_F002);
    wr_cfg("R4", 5'd6, 8'h18);
    do_read("R10", 5'd6);
    wr_cfg("R4", 5'd6, 8'h00);
    do_read("R10", 5'd6);
    wr_cfg("R4", 5'd6, 8'h08);
    do_read("R10", 5'd6);
    wr_cfg("R4", 5'd6, 8'h1F);
    do_read("R10", 5'd6);
    // R9: index out of range
    wr_addr(5'd20, 32'hDEAD_BEEF);
    wr_cfg("R9", 5'd20, 8'h18);
    do_read("R9", 5'd20);
    do_read("R9", 5'd4);
    do_read("R9", 5'd31);
    // R11: same-cycle write and read
    wr_addr(5'd3, 32'h0000_0107);
    cfg_and_read("R11", 5'd3, 8'h18);
    addr_and_read("R11", 5'd3, 32'h0000_0200);
    // R2: highest in-range entry
    wr_addr(5'd15, 32'hFFFF_FFFF);
    wr_cfg("R2", 5'd15, 8'h0F);
    do_read("R2", 5'd15);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule